// File: doc/BRIEF.md
# Conditional Control-Flow Next-PC Unit

This unit works out the program counter that follows a control-flow instruction in a small core with 16-bit instruction words. The decode stage issues one operation per cycle. With it come the current PC, the status flag byte, a flag selector and polarity, a raw offset field, the 16-bit pointer register, the result of a skip test, and whether the instruction after the current one is two words long. One clock later the unit returns the next PC, whether control flow left the sequential path, and how many cycles the instruction occupies.

The operations are: branch on one selected flag being set or clear, the signed branches (greater-or-equal and less-than), the unsigned branches (same-or-higher and lower), unconditional relative jump, indirect jump through the pointer, and skip-next-instruction. A skip steps over the following instruction. It therefore advances by two or three words, depending on how long the skipped instruction is, and its cycle count follows that length. All target arithmetic wraps at the program memory size, which is 2^PC_W words.

Top module: `pc_flow_unit`

## Requirements
- R1: While rst_n is low, and afterwards until the first issue, res_valid, next_pc, taken and cycles all read 0.
- R2: Results are registered. res_valid is 1 in the cycle after a cycle with issue high and 0 in the cycle after a cycle with issue low. next_pc, taken and cycles describe the operation issued in that earlier cycle.
- R3: Operation code 1 is a single-flag branch. It is taken when flags[flag_sel] equals flag_pol. When taken, the target is pc + k + 1, where k is offset[6:0] read as a two's-complement value.
- R4: Every conditional branch (codes 1 to 5) takes 2 cycles when taken. When not taken it takes 1 cycle and yields pc + 1 with taken = 0.
- R5: Code 2 (signed greater-or-equal) is taken when flags[2] XOR flags[3] is 0. Code 3 (signed less-than) is taken when that XOR is 1. Both use the 7-bit offset.
- R6: Code 4 (unsigned same-or-higher) is taken when flags[0] is 0. Code 5 (unsigned lower) is taken when flags[0] is 1. Both use the 7-bit offset.
- R7: Code 6 (relative jump) is always taken and yields pc + k + 1, where k is offset[11:0] read as two's complement. It takes 2 cycles.
- R8: Code 7 (indirect jump) is always taken. It loads the low PC_W bits of zptr and takes 2 cycles.
- R9: Code 8 (skip) with skip_hit = 1 reports taken = 1. It yields pc + 2 and 2 cycles when next_long = 0, and pc + 3 and 3 cycles when next_long = 1.
- R10: Code 8 with skip_hit = 0 yields pc + 1 and 1 cycle, with taken = 0, whatever next_long is.
- R11: Every computed next PC wraps modulo 2^PC_W, at both the top and the bottom of program memory.
- R12: Code 0 and every unlisted code (9 to 15) yield pc + 1, 1 cycle and taken = 0, regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code (see requirements) |
| pc | input | PC_W | Word address of the current instruction |
| flags | input | 8 | Status flags: bit 0 carry, bit 2 negative, bit 3 overflow |
| flag_sel | input | 3 | Flag tested by the single-flag branch |
| flag_pol | input | 1 | 1: branch if the flag is set, 0: branch if it is clear |
| offset | input | 12 | Raw signed offset; branches use bits 6:0, the relative jump uses all 12 |
| zptr | input | 16 | Pointer register for the indirect jump |
| skip_hit | input | 1 | Skip test result |
| next_long | input | 1 | The instruction after this one is two words long |
| res_valid | output | 1 | Registered result is valid |
| next_pc | output | PC_W | Next program counter |
| taken | output | 1 | Control flow left the sequential path |
| cycles | output | 2 | Cycles the instruction occupies |

## Verification
Two functions can meet in one cycle: the offset or skip addition and the wraparound at the edge of program memory. The bench provokes this with a branch and a skip placed at the top word, a relative jump whose maximum forward offset lands back on its own address, and a maximum backward jump from a low address. In every case the expected word is computed in the bench as a plain integer reduced modulo the memory size. A skip over a two-word instruction is also checked against a one-word one with the same PC, which shows that the extra word and the extra cycle move together.

// File: rtl/pc_flow_unit.sv
module pc_flow_unit #(
  parameter int PC_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [3:0]      op,
  input  logic [PC_W-1:0] pc,
  input  logic [7:0]      flags,
  input  logic [2:0]      flag_sel,
  input  logic            flag_pol,
  input  logic [11:0]     offset,
  input  logic [15:0]     zptr,
  input  logic            skip_hit,
  input  logic            next_long,
  output logic            res_valid,
  output logic [PC_W-1:0] next_pc,
  output logic            taken,
  output logic [1:0]      cycles
);

  localparam logic [3:0] OP_SEQ  = 4'd0;
  localparam logic [3:0] OP_BFLG = 4'd1;
  localparam logic [3:0] OP_BGE  = 4'd2;
  localparam logic [3:0] OP_BLT  = 4'd3;
  localparam logic [3:0] OP_BSH  = 4'd4;
  localparam logic [3:0] OP_BLO  = 4'd5;
  localparam logic [3:0] OP_RJMP = 4'd6;
  localparam logic [3:0] OP_IJMP = 4'd7;
  localparam logic [3:0] OP_SKIP = 4'd8;
  localparam int FC = 0;
  localparam int FN = 2;
  localparam int FV = 3;

  logic [15:0] pc16, short_k, long_k, short_tgt, long_tgt, seq_tgt, skip_tgt, tgt16;
  logic        br_cond, is_br, go;
  logic [1:0]  cyc_d;

  assign pc16      = 16'(pc);
  assign short_k   = {{9{offset[6]}}, offset[6:0]};
  assign long_k    = {{4{offset[11]}}, offset};
  assign short_tgt = pc16 + short_k + 16'd1;
  assign long_tgt  = pc16 + long_k + 16'd1;
  assign seq_tgt   = pc16 + 16'd1;
  assign skip_tgt  = pc16 + (next_long ? 16'd3 : 16'd2);

  always_comb begin
    br_cond = 1'b0;
    is_br   = 1'b1;
    unique case (op)
      OP_BFLG: br_cond = (flags[flag_sel] == flag_pol);
      OP_BGE:  br_cond = ~(flags[FN] ^ flags[FV]);
      OP_BLT:  br_cond =  (flags[FN] ^ flags[FV]);
      OP_BSH:  br_cond = ~flags[FC];
      OP_BLO:  br_cond =  flags[FC];
      default: is_br   = 1'b0;
    endcase
  end

  always_comb begin
    tgt16 = seq_tgt;
    go    = 1'b0;
    cyc_d = 2'd1;
    if (is_br) begin
      if (br_cond) begin
        tgt16 = short_tgt;
        go    = 1'b1;
        cyc_d = 2'd2;
      end
    end else begin
      case (op)
        OP_RJMP: begin tgt16 = long_tgt; go = 1'b1; cyc_d = 2'd2; end
        OP_IJMP: begin tgt16 = zptr;     go = 1'b1; cyc_d = 2'd2; end
        OP_SKIP: if (skip_hit) begin
          tgt16 = skip_tgt;
          go    = 1'b1;
          cyc_d = next_long ? 2'd3 : 2'd2;
        end
        default: ;
      endcase
    end
  end

  logic [PC_W-1:0] pc_q;
  logic [3:0]      op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      next_pc   <= '0;
      taken     <= 1'b0;
      cycles    <= 2'd0;
      pc_q      <= '0;
      op_q      <= OP_SEQ;
    end else begin
      res_valid <= issue;
      if (issue) begin
        next_pc <= tgt16[PC_W-1:0];
        taken   <= go;
        cycles  <= cyc_d;
        pc_q    <= pc;
        op_q    <= op;
      end
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> res_valid);

  p_idle_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !res_valid);

  p_taken_branch_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && taken && op_q != OP_SKIP) |-> cycles == 2'd2);

  p_not_taken_seq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !taken) |-> (cycles == 2'd1 && next_pc == PC_W'(pc_q + 1'b1)));

  p_skip_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && taken && op_q == OP_SKIP) |->
      (cycles != 2'd1 && next_pc == PC_W'(pc_q + PC_W'(cycles))));

  p_cycles_nonzero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> cycles != 2'd0);

endmodule

// File: tb/sim_pc_flow_unit.sv
module sim_pc_flow_unit;
  localparam int PW = 11;
  localparam int MEM = 1 << PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue = 1'b0;
  logic [3:0] op = '0;
  logic [PW-1:0] pc = '0;
  logic [7:0] flags = '0;
  logic [2:0] flag_sel = '0;
  logic flag_pol = 1'b0;
  logic [11:0] offset = '0;
  logic [15:0] zptr = '0;
  logic skip_hit = 1'b0;
  logic next_long = 1'b0;
  logic res_valid;
  logic [PW-1:0] next_pc;
  logic taken;
  logic [1:0] cycles;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pc_flow_unit #(.PC_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .pc(pc), .flags(flags),
    .flag_sel(flag_sel), .flag_pol(flag_pol), .offset(offset), .zptr(zptr),
    .skip_hit(skip_hit), .next_long(next_long), .res_valid(res_valid),
    .next_pc(next_pc), .taken(taken), .cycles(cycles));

  function automatic int wrapv(int v);
    return ((v % MEM) + MEM) % MEM;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(string req, logic [3:0] o, int p, logic [7:0] f,
                     logic [2:0] s, logic pol, logic [11:0] off, logic [15:0] z,
                     logic sh, logic nl, int e_pc, int e_tk, int e_cy);
    @(negedge clk);
    issue = 1'b1; op = o; pc = PW'(p); flags = f; flag_sel = s; flag_pol = pol;
    offset = off; zptr = z; skip_hit = sh; next_long = nl;
    @(negedge clk);
    issue = 1'b0;
    check({req, " valid"}, int'(res_valid), 1);
    check({req, " next_pc"}, int'(next_pc), e_pc);
    check({req, " taken"}, int'(taken), e_tk);
    check({req, " cycles"}, int'(cycles), e_cy);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 valid", int'(res_valid), 0);
    check("R1 next_pc", int'(next_pc), 0);
    check("R1 taken", int'(taken), 0);
    check("R1 cycles", int'(cycles), 0);
  endtask

  task automatic t_flag_branch;
    run("R3 set taken", 4'd1, 100, 8'h04, 3'd2, 1'b1, 12'd5, 16'h0, 1'b0, 1'b0, wrapv(100+5+1), 1, 2);
    run("R4 clear not taken", 4'd1, 100, 8'h04, 3'd2, 1'b0, 12'd5, 16'h0, 1'b0, 1'b0, 101, 0, 1);
    run("R3 negative k", 4'd1, 200, 8'h80, 3'd7, 1'b1, 12'h040, 16'h0, 1'b0, 1'b0, wrapv(200-64+1), 1, 2);
    run("R3 clear taken", 4'd1, 300, 8'hFE, 3'd0, 1'b0, 12'h07F, 16'h0, 1'b0, 1'b0, wrapv(300-1+1), 1, 2);
  endtask

  task automatic t_signed;
    run("R5 ge N=V", 4'd2, 400, 8'h0C, 3'd0, 1'b0, 12'd10, 16'h0, 1'b0, 1'b0, 411, 1, 2);
    run("R5 ge N!=V", 4'd2, 400, 8'h04, 3'd0, 1'b0, 12'd10, 16'h0, 1'b0, 1'b0, 401, 0, 1);
    run("R5 lt N!=V", 4'd3, 400, 8'h08, 3'd0, 1'b0, 12'h07E, 16'h0, 1'b0, 1'b0, wrapv(400-2+1), 1, 2);
    run("R5 lt N=V", 4'd3, 400, 8'h00, 3'd0, 1'b0, 12'd10, 16'h0, 1'b0, 1'b0, 401, 0, 1);
  endtask

  task automatic t_unsigned;
    run("R6 sh C=0", 4'd4, 500, 8'hFE, 3'd0, 1'b0, 12'd63, 16'h0, 1'b0, 1'b0, 564, 1, 2);
    run("R6 sh C=1", 4'd4, 500, 8'h01, 3'd0, 1'b0, 12'd63, 16'h0, 1'b0, 1'b0, 501, 0, 1);
    run("R6 lo C=1", 4'd5, 500, 8'h01, 3'd0, 1'b0, 12'd3, 16'h0, 1'b0, 1'b0, 504, 1, 2);
    run("R6 lo C=0", 4'd5, 500, 8'h00, 3'd0, 1'b0, 12'd3, 16'h0, 1'b0, 1'b0, 501, 0, 1);
  endtask

  task automatic t_jumps;
    run("R7 rjmp fwd", 4'd6, 20, 8'h00, 3'd0, 1'b0, 12'd300, 16'h0, 1'b0, 1'b0, 321, 1, 2);
    run("R7 R11 rjmp max fwd", 4'd6, 10, 8'h00, 3'd0, 1'b0, 12'h7FF, 16'h0, 1'b0, 1'b0, wrapv(10+2047+1), 1, 2);
    run("R7 R11 rjmp max back", 4'd6, 5, 8'h00, 3'd0, 1'b0, 12'h800, 16'h0, 1'b0, 1'b0, wrapv(5-2048+1), 1, 2);
    run("R8 ijmp", 4'd7, 77, 8'h00, 3'd0, 1'b0, 12'd9, 16'hABCD, 1'b0, 1'b0, 16'hABCD % MEM, 1, 2);
  endtask

  task automatic t_skip;
    run("R9 skip one word", 4'd8, 50, 8'h00, 3'd0, 1'b0, 12'd0, 16'h0, 1'b1, 1'b0, 52, 1, 2);
    run("R9 skip two words", 4'd8, 50, 8'h00, 3'd0, 1'b0, 12'd0, 16'h0, 1'b1, 1'b1, 53, 1, 3);
    run("R10 skip no fire", 4'd8, 50, 8'h00, 3'd0, 1'b0, 12'd0, 16'h0, 1'b0, 1'b1, 51, 0, 1);
  endtask

  task automatic t_wrap;
    run("R11 branch at top", 4'd4, MEM-1, 8'h00, 3'd0, 1'b0, 12'd3, 16'h0, 1'b0, 1'b0, wrapv(MEM-1+3+1), 1, 2);
    run("R11 seq at top", 4'd0, MEM-1, 8'h00, 3'd0, 1'b0, 12'd0, 16'h0, 1'b0, 1'b0, 0, 0, 1);
    run("R11 skip near top", 4'd8, MEM-2, 8'h00, 3'd0, 1'b0, 12'd0, 16'h0, 1'b1, 1'b1, wrapv(MEM-2+3), 1, 3);
  endtask

  task automatic t_seq;
    run("R12 seq", 4'd0, 600, 8'hFF, 3'd5, 1'b1, 12'd40, 16'h1234, 1'b1, 1'b1, 601, 0, 1);
    run("R12 unlisted", 4'd15, 600, 8'hFF, 3'd5, 1'b1, 12'd40, 16'h1234, 1'b1, 1'b1, 601, 0, 1);
    run("R12 code 9", 4'd9, 700, 8'h00, 3'd0, 1'b0, 12'd1, 16'h0, 1'b1, 1'b0, 701, 0, 1);
  endtask

  task automatic t_valid;
    @(negedge clk);
    check("R2 idle valid low", int'(res_valid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_flag_branch();
    t_signed();
    t_unsigned();
    t_jumps();
    t_skip();
    t_wrap();
    t_seq();
    t_valid();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule